// File: doc/BRIEF.md
# Two-Lane Word Deskew Aligner

This block joins two receive lanes into one wide word. Each lane already delivers byte-aligned code groups, 8 bits wide, or 10 bits wide when raw code groups are passed through. Each lane also raises a one-cycle marker wherever a word boundary is meant to fall. Both lanes pass through a short tapped delay line, 8 code groups deep. While the block searches, a marker on one lane opens a wait window of 4 code groups for the marker on the other lane. When the second marker arrives in time, the leading lane is given extra delay equal to the measured skew. The two markers then leave their delay lines in the same cycle, and the output word carries them side by side.

Once aligned, the block holds its delay settings whatever drift appears later. Markers that arrive after lock are ignored. The alignment is given up only on a loss condition: byte lock missing on a lane, a FIFO error on a lane, the transceiver disable input, or word sync switched off. Holding drop-sync together with disable for two consecutive clocks also clears the stored delays. With the mode select at 00 the block is a plain pass-through.

Top module: `word_deskew`

## Requirements
- R1: With `wsync_mode` = 00, the block passes data straight through. `word_out[7:0]` is the lane 0 code group and `word_out[15:8]` is the lane 1 code group, both delayed by exactly one cycle. `word_valid` is 1 and `word_lock` is 0.
- R2: With `wsync_mode` non-zero and the block searching, markers sampled on both lanes in the same cycle set lock with zero skew. On the next cycle `word_lock` and `word_valid` are 1 and `word_out` holds the two marked code groups.
- R3: When the lane 0 marker leads the lane 1 marker by 1 to 3 cycles, lock is acquired on the cycle after the lane 1 marker. From then on lane 0 is delayed by that skew more than lane 1, so both marked code groups appear in the same `word_out`.
- R4: The same rule applies with the lanes swapped: when lane 1 leads by 1 to 3 cycles, lane 1 receives the extra delay.
- R5: A marker followed by no marker on the other lane within 3 cycles is discarded. This covers a skew of 4 or more and a marker on one lane only. The block stays unlocked and keeps searching.
- R6: Once locked, later markers on either lane, at any skew, change neither `word_lock` nor the lane delays.
- R7: If either `lane0_blk` or `lane1_blk` is low, `word_lock` is 0 on the next cycle. No markers are accepted while either is low.
- R8: If either `lane0_ferr` or `lane1_ferr` is high, `word_lock` is 0 on the next cycle.
- R9: If `xcvr_dis` is high, `word_lock` is 0 on the next cycle, and the lane delays found earlier stay in effect on `word_out`. `drop_sync` asserted without `xcvr_dis` has no effect.
- R10: If `drop_sync` and `xcvr_dis` are both high for two consecutive sampled cycles, both lane delays return to zero skew.
- R11: When `wsync_mode` is non-zero and the block is not locked, `word_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code group clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wsync_mode | input | 2 | 00 selects pass-through; any other value enables word alignment |
| lane0_cg | input | CG_W | Lane 0 code group (CG_W is 8, or 10 with RAW_CG=1) |
| lane1_cg | input | CG_W | Lane 1 code group |
| lane0_evt | input | 1 | Lane 0 word-boundary marker |
| lane1_evt | input | 1 | Lane 1 word-boundary marker |
| lane0_blk | input | 1 | Lane 0 byte alignment held |
| lane1_blk | input | 1 | Lane 1 byte alignment held |
| lane0_ferr | input | 1 | Lane 0 FIFO overrun or underrun |
| lane1_ferr | input | 1 | Lane 1 FIFO overrun or underrun |
| xcvr_dis | input | 1 | Transceiver disable |
| drop_sync | input | 1 | Explicit sync invalidate, qualified by xcvr_dis |
| word_out | output | 2*CG_W | Lane 1 code group in the upper half, lane 0 in the lower half |
| word_valid | output | 1 | Word is aligned, or the block is in pass-through |
| word_lock | output | 1 | Word alignment held |

## Verification
Two functions can meet in one cycle: acquisition and loss. This is provoked by driving a loss condition, such as byte lock low, in the very cycle that carries both markers or the late marker. The result is judged by `word_lock` staying 0. A second collision puts markers on both lanes in the cycle that closes the wait window. The markers are placed at random skews of 0 to 3 cycles, and the bench checks the paired bytes against its own record of what each lane was sent.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
    localparam int NUM_LANES = 2;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_WAIT0  = 2'd1,
        ST_WAIT1  = 2'd2,
        ST_LOCK   = 2'd3
    } dsk_state_e;
endpackage

// File: rtl/lane_delay.sv
module lane_delay #(
    parameter int CG_W  = 8,
    parameter int DEPTH = 8,
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CG_W-1:0] din,
    input  logic [TW-1:0]   tap,
    output logic [CG_W-1:0] dout
);
    logic [CG_W-1:0] mem_q [DEPTH];
    logic [CG_W-1:0] mem_d [DEPTH];

    // stage 0 takes the new code group, the rest shift by one
    always_comb begin
        mem_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign dout = mem_q[tap];

    // R1: tap zero gives exactly one cycle of delay
    assert_tap0_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tap == '0) |=> (mem_q[0] == $past(din)));
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
    import deskew_pkg::*;
#(
    parameter int WIN   = 4,
    parameter int DEPTH = 8,
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_en,
    input  logic [1:0]    evt,
    input  logic          loss,
    input  logic          drop_req,
    output logic [TW-1:0] tap0,
    output logic [TW-1:0] tap1,
    output logic          locked
);
    typedef struct packed {
        dsk_state_e    state;
        logic [TW-1:0] cnt;
        logic [TW-1:0] tap0;
        logic [TW-1:0] tap1;
        logic          drop_seen;
    } ctrl_s;

    ctrl_s st_q, st_d;
    localparam logic [TW-1:0] LAST_WAIT = TW'(WIN - 1);

    always_comb begin
        st_d = st_q;
        st_d.drop_seen = drop_req;
        if (loss || !sync_en) begin
            st_d.state = ST_SEARCH;
            st_d.cnt   = '0;
        end else begin
            case (st_q.state)
                ST_SEARCH: begin
                    if (evt == 2'b11) begin
                        st_d.state = ST_LOCK;
                        st_d.tap0  = '0;
                        st_d.tap1  = '0;
                    end else if (evt[0]) begin
                        st_d.state = ST_WAIT0;
                        st_d.cnt   = TW'(1);
                    end else if (evt[1]) begin
                        st_d.state = ST_WAIT1;
                        st_d.cnt   = TW'(1);
                    end
                end
                ST_WAIT0: begin
                    if (evt[1]) begin
                        st_d.state = ST_LOCK;
                        st_d.tap0  = st_q.cnt;
                        st_d.tap1  = '0;
                    end else if (evt[0]) begin
                        st_d.cnt = TW'(1);
                    end else if (st_q.cnt == LAST_WAIT) begin
                        st_d.state = ST_SEARCH;
                    end else begin
                        st_d.cnt = st_q.cnt + TW'(1);
                    end
                end
                ST_WAIT1: begin
                    if (evt[0]) begin
                        st_d.state = ST_LOCK;
                        st_d.tap1  = st_q.cnt;
                        st_d.tap0  = '0;
                    end else if (evt[1]) begin
                        st_d.cnt = TW'(1);
                    end else if (st_q.cnt == LAST_WAIT) begin
                        st_d.state = ST_SEARCH;
                    end else begin
                        st_d.cnt = st_q.cnt + TW'(1);
                    end
                end
                default: ;
            endcase
        end
        if (drop_req && st_q.drop_seen) begin
            st_d.tap0 = '0;
            st_d.tap1 = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_SEARCH, cnt: '0, tap0: '0, tap1: '0, drop_seen: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tap0   = st_q.tap0;
    assign tap1   = st_q.tap1;
    assign locked = (st_q.state == ST_LOCK);

    // R2: lock is only ever entered on a sampled marker
    assert_lock_on_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(evt != 2'b00));
    // R3: only one lane carries extra delay
    assert_single_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tap0 == '0) || (tap1 == '0));
    // R5: skew never exceeds the wait window
    assert_skew_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tap0 <= LAST_WAIT) && (tap1 <= LAST_WAIT));
    // R6: lock and delays hold while no loss is present
    assert_hold_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !loss && sync_en && !drop_req) |=> (locked && $stable(tap0) && $stable(tap1)));
    // R10: two qualified drop cycles clear the delays
    assert_drop_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_req && $past(drop_req)) |=> (tap0 == '0 && tap1 == '0));
endmodule

// File: rtl/word_deskew.sv
module word_deskew
    import deskew_pkg::*;
#(
    parameter bit RAW_CG = 1'b0,
    parameter int DEPTH  = 8,
    parameter int WIN    = 4,
    localparam int CG_W  = RAW_CG ? 10 : 8,
    localparam int TW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        wsync_mode,
    input  logic [CG_W-1:0]   lane0_cg,
    input  logic [CG_W-1:0]   lane1_cg,
    input  logic              lane0_evt,
    input  logic              lane1_evt,
    input  logic              lane0_blk,
    input  logic              lane1_blk,
    input  logic              lane0_ferr,
    input  logic              lane1_ferr,
    input  logic              xcvr_dis,
    input  logic              drop_sync,
    output logic [2*CG_W-1:0] word_out,
    output logic              word_valid,
    output logic              word_lock
);
    logic              sync_en;
    logic              loss;
    logic [TW-1:0]     tap_ctrl [NUM_LANES];
    logic [TW-1:0]     tap_use  [NUM_LANES];
    logic [CG_W-1:0]   cg_in    [NUM_LANES];
    logic [CG_W-1:0]   cg_out   [NUM_LANES];

    assign sync_en  = (wsync_mode != 2'b00);
    assign loss     = xcvr_dis | ~lane0_blk | ~lane1_blk | lane0_ferr | lane1_ferr;
    assign cg_in[0] = lane0_cg;
    assign cg_in[1] = lane1_cg;

    deskew_ctrl #(.WIN(WIN), .DEPTH(DEPTH)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_en  (sync_en),
        .evt      ({lane1_evt, lane0_evt}),
        .loss     (loss),
        .drop_req (xcvr_dis & drop_sync),
        .tap0     (tap_ctrl[0]),
        .tap1     (tap_ctrl[1]),
        .locked   (word_lock)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign tap_use[g] = sync_en ? tap_ctrl[g] : '0;
        lane_delay #(.CG_W(CG_W), .DEPTH(DEPTH)) dly_i (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (cg_in[g]),
            .tap   (tap_use[g]),
            .dout  (cg_out[g])
        );
        assign word_out[g*CG_W +: CG_W] = cg_out[g];
    end

    assign word_valid = word_lock | ~sync_en;

    // R7: missing byte lock on a lane releases word lock
    assert_blk_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lane0_blk && lane1_blk) |=> !word_lock);
    // R8: a lane FIFO error releases word lock
    assert_ferr_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lane0_ferr || lane1_ferr) |=> !word_lock);
    // R9: disable releases word lock
    assert_dis_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_dis |=> !word_lock);
    // R11: nothing is flagged valid while aligning and unlocked
    assert_valid_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && !word_lock) |-> !word_valid);
endmodule

// File: tb/word_deskew_tb.sv
module word_deskew_tb_top;
    localparam int CG_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        wsync_mode = 2'b01;
    logic [CG_W-1:0]   lane0_cg = '0, lane1_cg = '0;
    logic              lane0_evt = 1'b0, lane1_evt = 1'b0;
    logic              lane0_blk = 1'b1, lane1_blk = 1'b1;
    logic              lane0_ferr = 1'b0, lane1_ferr = 1'b0;
    logic              xcvr_dis = 1'b0, drop_sync = 1'b0;
    logic [2*CG_W-1:0] word_out;
    logic              word_valid, word_lock;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    logic [CG_W-1:0] hist0 [8192];
    logic [CG_W-1:0] hist1 [8192];

    always #5 clk = ~clk;

    word_deskew dut_i (
        .clk(clk), .rst_n(rst_n), .wsync_mode(wsync_mode),
        .lane0_cg(lane0_cg), .lane1_cg(lane1_cg),
        .lane0_evt(lane0_evt), .lane1_evt(lane1_evt),
        .lane0_blk(lane0_blk), .lane1_blk(lane1_blk),
        .lane0_ferr(lane0_ferr), .lane1_ferr(lane1_ferr),
        .xcvr_dis(xcvr_dis), .drop_sync(drop_sync),
        .word_out(word_out), .word_valid(word_valid), .word_lock(word_lock)
    );

    function automatic logic [2*CG_W-1:0] exp_word(int t0, int t1);
        return {hist1[cyc-1-t1], hist0[cyc-1-t0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick(logic e0, logic e1);
        lane0_cg  = CG_W'($urandom);
        lane1_cg  = CG_W'($urandom);
        lane0_evt = e0;
        lane1_evt = e1;
        hist0[cyc] = lane0_cg;
        hist1[cyc] = lane1_cg;
        @(posedge clk);
        cyc++;
        #2;
        lane0_evt = 1'b0;
        lane1_evt = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
    endtask

    // lead: lane whose marker comes first; s: skew in cycles
    task automatic acquire(int lead, int s, string req);
        idle(5);
        if (s == 0) begin
            tick(1'b1, 1'b1);
        end else begin
            tick(lead == 0, lead == 1);
            for (int i = 1; i < s; i++) begin
                check(req, {31'd0, word_lock}, 32'd0);
                tick(1'b0, 1'b0);
            end
            tick(lead == 1, lead == 0);
        end
        check(req, {31'd0, word_lock}, 32'd1);
        check(req, {31'd0, word_valid}, 32'd1);
        check(req, word_out, exp_word(lead == 0 ? s : 0, lead == 1 ? s : 0));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5171));
        repeat (3) @(posedge clk);
        #2;
        check("R11 reset", {31'd0, word_lock}, 32'd0);
        check("R11 reset", {31'd0, word_valid}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R1: pass-through
        wsync_mode = 2'b00;
        idle(2);
        for (int i = 0; i < 4; i++) begin
            tick(1'b1, 1'b0);
            check("R1 passthru", word_out, exp_word(0, 0));
            check("R1 passthru valid", {30'd0, word_valid, word_lock}, 32'd2);
        end
        wsync_mode = 2'b10;

        // R2/R3/R4 directed skews
        acquire(0, 0, "R2");
        for (int s = 1; s <= 3; s++) begin
            wsync_mode = 2'b00; idle(1); wsync_mode = 2'b01;
            acquire(0, s, "R3");
            idle(2);
            check("R3 hold", word_out, exp_word(s, 0));
            wsync_mode = 2'b00; idle(1); wsync_mode = 2'b11;
            acquire(1, s, "R4");
            idle(2);
            check("R4 hold", word_out, exp_word(0, s));
        end

        // R5: skew 4 and single-lane marker
        wsync_mode = 2'b00; idle(1); wsync_mode = 2'b01;
        idle(5);
        tick(1'b1, 1'b0); idle(3); tick(1'b0, 1'b1);
        check("R5 skew4", {31'd0, word_lock}, 32'd0);
        idle(6);
        check("R5 skew4", {31'd0, word_lock}, 32'd0);
        tick(1'b0, 1'b1); idle(8);
        check("R5 single", {31'd0, word_lock}, 32'd0);
        check("R11 unlocked", {31'd0, word_valid}, 32'd0);

        // R6: drift after lock is ignored
        acquire(1, 2, "R6 acq");
        tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b1);
        tick(1'b1, 1'b1);
        check("R6 lock", {31'd0, word_lock}, 32'd1);
        check("R6 taps", word_out, exp_word(0, 2));

        // R7: byte lock loss, plus a collision with markers
        lane1_blk = 1'b0;
        tick(1'b1, 1'b1);
        check("R7 blk", {31'd0, word_lock}, 32'd0);
        check("R11 blk", {31'd0, word_valid}, 32'd0);
        tick(1'b1, 1'b1);
        check("R7 no acq", {31'd0, word_lock}, 32'd0);
        lane1_blk = 1'b1;

        // R8: FIFO error
        acquire(0, 1, "R8 acq");
        lane0_ferr = 1'b1; tick(1'b0, 1'b0); lane0_ferr = 1'b0;
        check("R8 ferr", {31'd0, word_lock}, 32'd0);

        // R9: drop_sync alone, then disable keeps delays
        acquire(0, 3, "R9 acq");
        drop_sync = 1'b1; tick(1'b0, 1'b0); drop_sync = 1'b0;
        check("R9 drop alone", {31'd0, word_lock}, 32'd1);
        xcvr_dis = 1'b1; tick(1'b0, 1'b0); xcvr_dis = 1'b0;
        check("R9 dis", {31'd0, word_lock}, 32'd0);
        idle(1);
        check("R9 keep taps", word_out, exp_word(3, 0));

        // R10: qualified drop for two cycles clears delays
        xcvr_dis = 1'b1; drop_sync = 1'b1;
        idle(2);
        xcvr_dis = 1'b0; drop_sync = 1'b0;
        idle(1);
        check("R10 cleared", word_out, exp_word(0, 0));
        check("R10 unlocked", {31'd0, word_lock}, 32'd0);

        // random trials with random loss causes
        for (int k = 0; k < 40; k++) begin
            int lead, s, cause;
            lead = int'($urandom % 2);
            s    = int'($urandom % 4);
            acquire(lead, s, s == 0 ? "R2 rnd" : (lead == 0 ? "R3 rnd" : "R4 rnd"));
            idle(int'($urandom % 3));
            check("R6 rnd", word_out, exp_word(lead == 0 ? s : 0, lead == 1 ? s : 0));
            cause = int'($urandom % 4);
            case (cause)
                0: lane0_blk = 1'b0;
                1: lane1_ferr = 1'b1;
                2: xcvr_dis = 1'b1;
                default: wsync_mode = 2'b00;
            endcase
            tick(1'b1, 1'b1);
            check(cause == 0 ? "R7 rnd" : cause == 1 ? "R8 rnd" : cause == 2 ? "R9 rnd" : "R1 rnd",
                  {31'd0, word_lock}, 32'd0);
            lane0_blk = 1'b1; lane1_ferr = 1'b0; xcvr_dis = 1'b0; wsync_mode = 2'b01;
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule